// File: doc/BRIEF.md
# Byte-Lane Synchronous Burst Memory

A single-port synchronous memory of 18-bit words, split into two independently writable 9-bit lanes. Address, write data, lane write enables, the two address strobes, the chip select and the advance input are all sampled on the rising clock edge. A write lands in the array on the edge that samples it. Read data is registered on the edge that samples the access, so it is available on `dataOut` in the cycle that follows.

An access is opened in one of two ways. The processor strobe loads a new base address and always reads; the lane enables are ignored on that edge. The controller strobe loads a base address and reads or writes according to the lane enables. With both strobes high, the burst continues from the loaded base. A low advance input steps the two low address bits, wrapping modulo four, while the upper address bits stay fixed. A high advance input repeats the current word. The chip select is looked at only when an address is loaded. The bidirectional data bus is modelled as `dataOut` plus a drive qualifier, `dataDrive`. The output enable gates `dataDrive` without passing through any register, and the qualifier is off after any write or deselect.

A two-cycle write from the processor side works as follows. The processor strobe loads the address as a read. On the next edge, both strobes are high and at least one lane enable is low, and that cycle writes the loaded address.

Top module: `sync_burst_mem`

## Requirements
- R1: `laneWrN[0]` low writes bits 8:0 and `laneWrN[1]` low writes bits 17:9 of the addressed word. A lane whose enable is high keeps its old contents.
- R2: `procStrobeN` low with `chipSelN` low loads `addrIn` as the burst base and performs a read whatever `laneWrN` is. A following cycle with both strobes high and a lane enable low writes that base word.
- R3: `ctrlStrobeN` low, `procStrobeN` high and `chipSelN` low load `addrIn` as the burst base. The cycle writes if any bit of `laneWrN` is low and reads otherwise.
- R4: `ctrlStrobeN` low with `chipSelN` high deselects the block. That cycle and every later cycle with both strobes high perform no access and leave `dataDrive` low, until a new address is loaded.
- R5: `procStrobeN` low while `chipSelN` and `ctrlStrobeN` are high is ignored, and the cycle acts as a burst continue.
- R6: In a continue cycle with `advanceN` low, the low two address bits advance by one before the access, wrapping modulo 4, while the upper bits keep the base value. A base b yields b, b+1, b+2, b+3 and then b again in the low bits.
- R7: In a continue cycle with `advanceN` high, the address does not change and a read returns the same word again.
- R8: `dataDrive` equals `outEnN` low AND "the last sampled cycle was a selected read". `outEnN` acts without a clock, and `dataOut` holds the read word after the edge that samples the read.
- R9: After an edge that samples a write, `dataDrive` is low whatever `outEnN` is.
- R10: A read in the cycle right after a write to the same address returns the newly written lanes.
- R11: While `rstN` is low and after it is released, the block is deselected and `dataDrive` is low until a read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of the burst and output state |
| addrIn | input | ADDR_W | External word address |
| procStrobeN | input | 1 | Processor address strobe, active low; load with read |
| ctrlStrobeN | input | 1 | Controller address strobe, active low; load with read or write |
| advanceN | input | 1 | Burst advance, active low |
| chipSelN | input | 1 | Chip select, active low, sampled only on a load |
| laneWrN | input | 2 | Lane write enables, active low; bit 0 is bits 8:0, bit 1 is bits 17:9 |
| outEnN | input | 1 | Output enable, active low, not clocked |
| dataIn | input | 18 | Write data |
| dataOut | output | 18 | Registered read data |
| dataDrive | output | 1 | High when the bus should be driven with `dataOut` |

## Verification
The bench first fills the array with controller-strobe writes, so every later read has a known word to return. Bursts from an aligned base and from a mid-group base separate a true modulo-4 wrap from a plain increment, and a suspended beat shows that the address does not move. Processor-strobe loads are applied with the lane enables low, to tell a read from a wrongly honoured write. They are then followed by the second write beat and an immediate read, which checks that the write reached the array. Single-lane writes, continue cycles after a deselect, and a processor strobe with the chip unselected each show up as a word that must stay unchanged or a drive that must stay off.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int LANE_W   = 9;
  localparam int LANE_CNT = 2;
  localparam int WORD_W   = LANE_W * LANE_CNT;
  localparam int BURST_W  = 2;

  typedef struct packed {
    logic                rdEn;
    logic [LANE_CNT-1:0] wrEn;
  } memStrobe_t;
endpackage

// File: rtl/sbm_burst_ctrl.sv
module sbm_burst_ctrl
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                advanceN,
  input  logic                chipSelN,
  input  logic [LANE_CNT-1:0] laneWrN,
  output logic [ADDR_W-1:0]   memAddr,
  output memStrobe_t          strobe
);
  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] beatCnt;
  logic [BURST_W-1:0] nextCnt;
  logic [BURST_W-1:0] lowBits;
  logic burstActive;
  logic procLoad, ctrlLoad, deselect, carryOn, step, access, loadNow;

  // Decode of the sampled control inputs; the processor strobe has priority.
  always_comb begin
    procLoad = !procStrobeN && !chipSelN;
    ctrlLoad = !procLoad && !ctrlStrobeN && !chipSelN;
    deselect = !procLoad && !ctrlStrobeN && chipSelN;
    carryOn  = !procLoad && ctrlStrobeN && burstActive;
    loadNow  = procLoad || ctrlLoad;
    step     = carryOn && !advanceN;
    access   = loadNow || carryOn;
    nextCnt  = beatCnt + {{(BURST_W-1){1'b0}}, step};
    lowBits  = baseAddr[BURST_W-1:0] + nextCnt;
    memAddr  = loadNow ? addrIn : {baseAddr[ADDR_W-1:BURST_W], lowBits};
    strobe.wrEn = (access && !procLoad) ? ~laneWrN : '0;
    strobe.rdEn = access && (procLoad || (&laneWrN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr    <= '0;
      beatCnt     <= '0;
      burstActive <= 1'b0;
    end else if (loadNow) begin
      baseAddr    <= addrIn;
      beatCnt     <= '0;
      burstActive <= 1'b1;
    end else if (deselect) begin
      burstActive <= 1'b0;
    end else if (step) begin
      beatCnt <= nextCnt;
    end
  end
endmodule

// File: rtl/sbm_datapath.sv
module sbm_datapath
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] memAddr,
  input  memStrobe_t        strobe,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rdValid;

  // One storage array per byte lane, each with its own write enable.
  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (strobe.wrEn[g]) laneMem[memAddr] <= dataIn[g*LANE_W +: LANE_W];
      if (strobe.rdEn)    laneQ <= laneMem[memAddr];
    end
    assign dataOut[g*LANE_W +: LANE_W] = laneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobe.rdEn;
  end

  assign dataDrive = !outEnN && rdValid;
endmodule

// File: rtl/sync_burst_mem.sv
module sync_burst_mem
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                advanceN,
  input  logic                chipSelN,
  input  logic [1:0]          laneWrN,
  input  logic                outEnN,
  input  logic [17:0]         dataIn,
  output logic [17:0]         dataOut,
  output logic                dataDrive
);
  logic [ADDR_W-1:0] memAddr;
  memStrobe_t        strobe;

  sbm_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .chipSelN(chipSelN), .laneWrN(laneWrN),
    .memAddr(memAddr), .strobe(strobe)
  );

  sbm_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .strobe(strobe),
    .dataIn(dataIn), .outEnN(outEnN),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );
endmodule

// File: rtl/sync_burst_mem_chk.sv
module sync_burst_mem_chk (
  input logic       clk,
  input logic       rstN,
  input logic       procStrobeN,
  input logic       ctrlStrobeN,
  input logic       chipSelN,
  input logic [1:0] laneWrN,
  input logic       outEnN,
  input logic       dataDrive
);
  // R8: a high output enable always keeps the bus released.
  assert_oe_gates_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataDrive);

  // R9: a sampled controller-strobe write leaves the bus released afterwards.
  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && procStrobeN && !ctrlStrobeN && (laneWrN != 2'b11)) |=> !dataDrive);

  // R4: a deselect leaves the bus released afterwards.
  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && chipSelN) |=> !dataDrive);

  // R2: a processor-strobe load is a read, so drive follows the output enable.
  assert_proc_load_reads_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !chipSelN) |=> (dataDrive == !outEnN));

  // R11: the bus is released on the first edge after reset is lifted.
  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !dataDrive);
endmodule

bind sync_burst_mem sync_burst_mem_chk u_chk (
  .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
  .chipSelN(chipSelN), .laneWrN(laneWrN), .outEnN(outEnN), .dataDrive(dataDrive)
);

// File: tb/sim_sync_burst_mem.sv
module sim_sync_burst_mem;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addrIn;
  logic          procStrobeN, ctrlStrobeN, advanceN, chipSelN, outEnN;
  logic [1:0]    laneWrN;
  logic [17:0]   dataIn, dataOut;
  logic          dataDrive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        drive;
    logic [17:0] data;
    string       tag;
  } item_t;
  item_t sbq[$];

  logic [17:0] mMem [DEPTH];
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt = '0;
  logic          mActive = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_mem #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .chipSelN(chipSelN),
    .laneWrN(laneWrN), .outEnN(outEnN), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 18'h04C1) ^ 18'h15A5A);
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one clocked cycle and pushes the expected result.
  task automatic cycle(input logic ps, input logic cs, input logic adv, input logic ce,
                       input logic [1:0] wr, input logic [AW-1:0] a,
                       input logic [17:0] d, input logic oe, input string tag);
    logic pL, cL, des, cont, acc, isWr;
    logic [AW-1:0] ea;
    item_t it;
    @(negedge clk);
    procStrobeN = ps; ctrlStrobeN = cs; advanceN = adv; chipSelN = ce;
    laneWrN = wr; addrIn = a; dataIn = d; outEnN = oe;
    pL   = !ps && !ce;
    cL   = !pL && !cs && !ce;
    des  = !pL && !cs && ce;
    cont = !pL && cs && mActive;
    if (pL || cL) begin mBase = a; mCnt = 2'd0; mActive = 1'b1; end
    else if (des) mActive = 1'b0;
    else if (cont && !adv) mCnt = mCnt + 2'd1;
    acc  = pL || cL || cont;
    ea   = {mBase[AW-1:2], 2'(mBase[1:0] + mCnt)};
    isWr = acc && !pL && (wr != 2'b11);
    if (isWr) begin
      if (!wr[0]) mMem[ea][8:0]  = d[8:0];
      if (!wr[1]) mMem[ea][17:9] = d[17:9];
    end
    it.drive = acc && !isWr && !oe;
    it.data  = mMem[ea];
    it.tag   = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares each cycle's outcome after its clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check({it.tag, " drive"}, {17'd0, dataDrive}, {17'd0, it.drive});
        if (it.drive) check({it.tag, " data"}, dataOut, it.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    rstN = 1'b0; procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1; chipSelN = 1;
    laneWrN = 2'b11; addrIn = '0; dataIn = '0; outEnN = 1;
    repeat (3) @(posedge clk);
    #1 outEnN = 0; #1;
    check("R11 drive in reset", {17'd0, dataDrive}, 18'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    check("R11 drive after reset", {17'd0, dataDrive}, 18'd0);

    // R3: fill with controller-strobe writes, then read a few back.
    for (int a = 0; a < 16; a++) cycle(1, 0, 1, 0, 2'b00, AW'(a), pat(a), 0, "R3 write");
    cycle(1, 0, 1, 0, 2'b11, 6'd11, 18'h0, 0, "R3 read");

    // R6: aligned burst with wrap, R7: suspended beat.
    cycle(1, 0, 1, 0, 2'b11, 6'd4, 18'h0, 0, "R6 base4");
    cycle(1, 1, 0, 1, 2'b11, 6'd0, 18'h0, 0, "R6 beat1");
    cycle(1, 1, 0, 1, 2'b11, 6'd0, 18'h0, 0, "R6 beat2");
    cycle(1, 1, 1, 1, 2'b11, 6'd0, 18'h0, 0, "R7 suspend");
    cycle(1, 1, 0, 1, 2'b11, 6'd0, 18'h0, 0, "R6 beat3");
    cycle(1, 1, 0, 1, 2'b11, 6'd0, 18'h0, 0, "R6 wrap");
    // R6: mid-group base 6 -> 7, 4, 5, 6.
    cycle(1, 0, 1, 0, 2'b11, 6'd6, 18'h0, 0, "R6 base6");
    for (int k = 0; k < 4; k++) cycle(1, 1, 0, 1, 2'b11, 6'd0, 18'h0, 0, "R6 midwrap");

    // R2: processor load with lane enables low reads; second beat writes; R10 read-back.
    cycle(0, 1, 1, 0, 2'b00, 6'd9, 18'h3FFFF, 0, "R2 first beat");
    cycle(1, 1, 1, 1, 2'b00, 6'd0, 18'h2ABCD, 0, "R2 R9 second beat");
    cycle(1, 0, 1, 0, 2'b11, 6'd9, 18'h0, 0, "R10 readback");

    // R1: single-lane writes.
    cycle(1, 0, 1, 0, 2'b10, 6'd2, 18'h3FFFF, 0, "R1 low lane write");
    cycle(1, 0, 1, 0, 2'b11, 6'd2, 18'h0, 0, "R1 low lane read");
    cycle(1, 0, 1, 0, 2'b01, 6'd3, 18'h00000, 0, "R1 high lane write");
    cycle(1, 0, 1, 0, 2'b11, 6'd3, 18'h0, 0, "R1 high lane read");

    // R4: deselect, then continue cycles with writes must not touch the array.
    cycle(1, 0, 1, 1, 2'b11, 6'd2, 18'h0, 0, "R4 deselect");
    cycle(1, 1, 0, 1, 2'b00, 6'd0, 18'h01234, 0, "R4 idle write");
    cycle(1, 1, 1, 0, 2'b00, 6'd0, 18'h01234, 0, "R4 idle write");
    cycle(1, 0, 1, 0, 2'b11, 6'd2, 18'h0, 0, "R4 unchanged");
    cycle(1, 1, 0, 0, 2'b11, 6'd0, 18'h0, 0, "R4 unchanged");

    // R5: processor strobe with chip unselected acts as continue.
    cycle(1, 0, 1, 0, 2'b11, 6'd12, 18'h0, 0, "R5 base12");
    cycle(0, 1, 0, 1, 2'b11, 6'd40, 18'h0, 0, "R5 ignored strobe");

    // R8: read with output enable high, then enable without a clock edge.
    cycle(1, 0, 1, 0, 2'b11, 6'd5, 18'h0, 1, "R8 oe high");
    @(posedge clk); #3;
    outEnN = 1'b0; #1;
    check("R8 async enable drive", {17'd0, dataDrive}, 18'd1);
    check("R8 async enable data", dataOut, mMem[5]);
    // R9: write with output enable low keeps drive off.
    cycle(1, 0, 1, 0, 2'b00, 6'd20, 18'h1F0F0, 0, "R9 write oe low");
    cycle(1, 0, 1, 0, 2'b11, 6'd20, 18'h0, 0, "R10 readback");
    cycle(1, 1, 1, 1, 2'b11, 6'd0, 18'h0, 1, "R8 idle");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule